// File: doc/BRIEF.md
# Serial Receive Queue Drain Sequencer

This block empties the receive queue of one serial controller channel. It does this through that controller's register port, which has a 4-bit register index and 8-bit data. After a single start pulse it repeats a fixed pattern for each character. It polls the status register for the character-available flag. If a character is waiting, it reads that character's error flags and then the data byte, in that order, because the data read consumes the flags. If any error flag was set, it writes the error-reset command to the command register. The byte itself is thrown away.

The loop ends as soon as a poll finds the queue empty, or after `MAX_ITER` characters. The limit keeps a missing or misbehaving device from holding the sequencer forever. On completion the block raises `done` for one cycle. It keeps the number of characters it discarded on `drained` until the next accepted start.

Top module: `rx_fifo_drain`

## Requirements
- R1: After reset `busy`, `done` and `reg_req` are 0 and `drained` is 0.
- R2: A `start` pulse seen while idle raises `busy`, clears `drained` and, on the next cycle, requests a read (`reg_we`=0) of register 0.
- R3: A read of register 0 whose bit 0 is 0 ends the run with no further register access; the other bits of register 0 are ignored.
- R4: For each available character the sequencer reads register 1 (error flags) first and register 8 (data) second, and counts the character at the register 8 read.
- R5: If bit 4 (parity), bit 5 (overrun) or bit 6 (framing) of the register 1 value is set, a write of 0x30 to register 0 follows the data read; bits 0 to 3 and 7 of register 1 play no part.
- R6: A character whose register 1 bits 4 to 6 are all 0 causes no register write.
- R7: After `MAX_ITER` characters the run ends without polling register 0 again, whatever the queue holds.
- R8: At the end of a run `drained` equals the number of characters discarded (0 to `MAX_ITER`) and holds that value while idle.
- R9: A `start` pulse while `busy` is 1 is ignored: the access sequence and `drained` are as if it never occurred.
- R10: `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` hold steady until a one-cycle `reg_ack`; `reg_rdata` is taken in the `reg_ack` cycle.
- R11: `done` is high for exactly one cycle per run, and `busy` is 0 on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a drain run |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 4 | Register index |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | One-cycle access completion |
| reg_rdata | input | 8 | Read data, valid with `reg_ack` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| drained | output | $clog2(MAX_ITER+1) | Characters discarded in the last run |

## Verification
The bench builds the block with `MAX_ITER` = 4, so the iteration limit can be reached and passed by queues that are only slightly deeper. Queue depths from 0 to 5 are swept against nine error-flag patterns, which cover each flag alone, flag combinations, error-free runs and unused status bits set. Ack latencies of 0 to 2 cycles are mixed in. Every access is logged and compared against a sequence built arithmetically from the queue depth and the flags. A second start is also pushed into busy runs to show that it is ignored.

// File: rtl/drain_pkg.sv
package drain_pkg;
  localparam int REG_IDX_W = 4;
  localparam int REG_DAT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_FLAGS,
    ST_DATA,
    ST_CLEAR,
    ST_FIN
  } drain_st_e;

  typedef struct packed {
    logic                 req;
    logic                 we;
    logic [REG_IDX_W-1:0] addr;
    logic [REG_DAT_W-1:0] wdata;
  } bus_op_t;
endpackage

// File: rtl/drain_tally.sv
module drain_tally #(
  parameter int MAX_ITER = 32,
  localparam int CNT_W = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count,
  output logic             last,
  output logic             full
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ITER);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (bump)  cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
  assign last  = (cnt_q == LIMIT - 1'b1);
  assign full  = (cnt_q == LIMIT);

  // R7: the discard count never passes the iteration limit
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
endmodule

// File: rtl/drain_fsm.sv
module drain_fsm import drain_pkg::*; #(
  parameter int READY_BIT = 0,
  parameter int PAR_BIT   = 4,
  parameter int OVR_BIT   = 5,
  parameter int FRM_BIT   = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 ack,
  input  logic [REG_DAT_W-1:0] rdata,
  input  logic                 cnt_last,
  input  logic                 cnt_full,
  output drain_st_e            st_n,
  output logic                 bump,
  output logic                 clear,
  output logic                 done,
  output logic                 busy
);
  localparam logic [REG_DAT_W-1:0] ERR_MASK =
    REG_DAT_W'((1 << PAR_BIT) | (1 << OVR_BIT) | (1 << FRM_BIT));

  drain_st_e st_q;
  logic      err_q;

  always_comb begin
    st_n  = st_q;
    bump  = 1'b0;
    clear = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n  = ST_POLL;
        clear = 1'b1;
      end
      ST_POLL:  if (ack) st_n = rdata[READY_BIT] ? ST_FLAGS : ST_FIN;
      ST_FLAGS: if (ack) st_n = ST_DATA;
      ST_DATA: if (ack) begin
        bump = 1'b1;
        if (err_q)         st_n = ST_CLEAR;
        else if (cnt_last) st_n = ST_FIN;
        else               st_n = ST_POLL;
      end
      ST_CLEAR: if (ack) st_n = cnt_full ? ST_FIN : ST_POLL;
      ST_FIN:   st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
      done  <= 1'b0;
      busy  <= 1'b0;
    end else begin
      st_q <= st_n;
      done <= (st_n == ST_FIN);
      busy <= (st_n != ST_IDLE);
      if (st_q == ST_FLAGS && ack) err_q <= |(rdata & ERR_MASK);
    end
  end

  // R6: a clear write is only ever entered for a flagged character
  a_r6_clear_after_flags: assert property (@(posedge clk) disable iff (rst)
    (st_n == ST_CLEAR && st_q != ST_CLEAR) |-> (st_q == ST_DATA && err_q));
endmodule

// File: rtl/drain_bus.sv
module drain_bus import drain_pkg::*; #(
  parameter logic [REG_IDX_W-1:0] POLL_REG  = 4'd0,
  parameter logic [REG_IDX_W-1:0] FLAG_REG  = 4'd1,
  parameter logic [REG_IDX_W-1:0] DATA_REG  = 4'd8,
  parameter logic [REG_IDX_W-1:0] CMD_REG   = 4'd0,
  parameter logic [REG_DAT_W-1:0] CLEAR_CMD = 8'h30
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      ack,
  input  drain_st_e st_n,
  output bus_op_t   op_q
);
  bus_op_t op_d;

  always_comb begin
    op_d = '0;
    case (st_n)
      ST_POLL:  begin op_d.req = 1'b1; op_d.addr = POLL_REG; end
      ST_FLAGS: begin op_d.req = 1'b1; op_d.addr = FLAG_REG; end
      ST_DATA:  begin op_d.req = 1'b1; op_d.addr = DATA_REG; end
      ST_CLEAR: begin
        op_d.req   = 1'b1;
        op_d.we    = 1'b1;
        op_d.addr  = CMD_REG;
        op_d.wdata = CLEAR_CMD;
      end
      default: op_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) op_q <= '0;
    else     op_q <= op_d;
  end

  // R10: an outstanding request is held unchanged until acknowledged
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (op_q.req && !ack) |=> (op_q.req && $stable(op_q)));
endmodule

// File: rtl/rx_fifo_drain.sv
module rx_fifo_drain import drain_pkg::*; #(
  parameter int MAX_ITER = 32,
  parameter int READY_BIT = 0,
  parameter int PAR_BIT = 4,
  parameter int OVR_BIT = 5,
  parameter int FRM_BIT = 6,
  parameter logic [REG_IDX_W-1:0] POLL_REG = 4'd0,
  parameter logic [REG_IDX_W-1:0] FLAG_REG = 4'd1,
  parameter logic [REG_IDX_W-1:0] DATA_REG = 4'd8,
  parameter logic [REG_IDX_W-1:0] CMD_REG = 4'd0,
  parameter logic [REG_DAT_W-1:0] CLEAR_CMD = 8'h30,
  localparam int CNT_W = $clog2(MAX_ITER + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [REG_IDX_W-1:0] reg_addr,
  output logic [REG_DAT_W-1:0] reg_wdata,
  input  logic                 reg_ack,
  input  logic [REG_DAT_W-1:0] reg_rdata,
  output logic                 busy,
  output logic                 done,
  output logic [CNT_W-1:0]     drained
);
  drain_st_e st_n;
  bus_op_t   op_q;
  logic      bump, clear, cnt_last, cnt_full;

  drain_fsm #(
    .READY_BIT(READY_BIT), .PAR_BIT(PAR_BIT),
    .OVR_BIT(OVR_BIT), .FRM_BIT(FRM_BIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .ack(reg_ack), .rdata(reg_rdata),
    .cnt_last(cnt_last), .cnt_full(cnt_full), .st_n(st_n),
    .bump(bump), .clear(clear), .done(done), .busy(busy)
  );

  drain_tally #(.MAX_ITER(MAX_ITER)) u_tally (
    .clk(clk), .rst(rst), .clear(clear), .bump(bump),
    .count(drained), .last(cnt_last), .full(cnt_full)
  );

  drain_bus #(
    .POLL_REG(POLL_REG), .FLAG_REG(FLAG_REG), .DATA_REG(DATA_REG),
    .CMD_REG(CMD_REG), .CLEAR_CMD(CLEAR_CMD)
  ) u_bus (
    .clk(clk), .rst(rst), .ack(reg_ack), .st_n(st_n), .op_q(op_q)
  );

  assign reg_req   = op_q.req;
  assign reg_we    = op_q.we;
  assign reg_addr  = op_q.addr;
  assign reg_wdata = op_q.wdata;

  // R2: an accepted start launches a poll read on the following cycle
  a_r2_start_launch: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (reg_req && !reg_we && reg_addr == POLL_REG));

  // R3: no register traffic while idle
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !reg_req);

  // R8: the reported count holds while idle and not restarted
  a_r8_count_held: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(drained));

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
endmodule

// File: tb/rx_fifo_drain_bench.sv
module rx_fifo_drain_bench;
  localparam int MAX = 4;
  localparam int CW  = $clog2(MAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic reg_req, reg_we, reg_ack, busy, done;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [CW-1:0] drained;

  always #2 clk = ~clk;

  rx_fifo_drain #(.MAX_ITER(MAX)) u_rx_fifo_drain (
    .clk(clk), .rst(rst), .start(start),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .drained(drained)
  );

  int nchk = 0, nerr = 0;
  int dev_avail, dev_idx, dev_pat, dev_lat, wcnt;
  int tr_n, done_cnt;
  logic [12:0] tr_log [64];
  logic [12:0] ex_log [64];
  logic [12:0] seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int flag_bits(input int idx, input int pat);
    return (pat == 8) ? 0 : ((pat + idx * 3) % 8);
  endfunction

  function automatic logic [7:0] flag_reg(input int idx, input int pat);
    return {1'(idx & 1), 3'(flag_bits(idx, pat)), 4'((idx * 5) & 15)};
  endfunction

  // device model for the register port
  initial begin
    reg_ack = 1'b0; reg_rdata = '0; wcnt = 0;
    dev_avail = 0; dev_idx = 0; dev_pat = 0; dev_lat = 0; tr_n = 0;
    forever begin
      @(negedge clk);
      if (reg_ack) begin
        reg_ack = 1'b0;
        wcnt = 0;
      end else if (reg_req && !rst) begin
        if (wcnt == 0) seen = {reg_we, reg_addr, reg_wdata};
        if (wcnt < dev_lat) wcnt++;
        else begin
          if (dev_lat > 0)
            chk(seen == {reg_we, reg_addr, reg_wdata}, "R10 request held",
                {reg_we, reg_addr, reg_wdata}, seen);
          if (tr_n < 64) tr_log[tr_n] = {reg_we, reg_addr, reg_wdata};
          tr_n++;
          reg_rdata = '0;
          if (!reg_we) begin
            if (reg_addr == 4'd0) reg_rdata = (dev_avail > 0) ? 8'hA5 : 8'hFE;
            else if (reg_addr == 4'd1) reg_rdata = flag_reg(dev_idx, dev_pat);
            else if (reg_addr == 4'd8) begin
              reg_rdata = 8'(dev_idx);
              if (dev_avail > 0) dev_avail--;
              dev_idx++;
            end
          end
          reg_ack = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic run_case(input int n, input int pat, input int lat, input bit dbl);
    int ne, nw_exp, nw_act, waited, exp_cnt;
    dev_avail = n; dev_idx = 0; dev_pat = pat; dev_lat = lat;
    tr_n = 0; done_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && reg_req && !reg_we && reg_addr == 4'd0, "R2 launch poll",
        {busy, reg_req, reg_we, reg_addr}, 7'b1100000);
    if (dbl) begin
      repeat (3) @(negedge clk);
      if (busy) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    waited = 0;
    while (done_cnt == 0 && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);
    exp_cnt = (n < MAX) ? n : MAX;
    chk(done_cnt == 1, "R11 single done", done_cnt, 1);
    chk(!busy && !reg_req, "R11 idle after done", {busy, reg_req}, 0);
    chk(drained == CW'(exp_cnt), dbl ? "R9 count unaffected" : "R8 count",
        int'(drained), exp_cnt);
    // expected access sequence
    ne = 0; nw_exp = 0;
    for (int i = 0; i < MAX; i++) begin
      ex_log[ne++] = {1'b0, 4'd0, 8'd0};
      if (i >= n) break;
      ex_log[ne++] = {1'b0, 4'd1, 8'd0};
      ex_log[ne++] = {1'b0, 4'd8, 8'd0};
      if (flag_bits(i, pat) != 0) begin
        ex_log[ne++] = {1'b1, 4'd0, 8'h30};
        nw_exp++;
      end
    end
    chk(tr_n == ne, (n >= MAX) ? "R7 access total" : "R3 access total", tr_n, ne);
    nw_act = 0;
    for (int k = 0; k < tr_n && k < 64; k++) if (tr_log[k][12]) nw_act++;
    chk(nw_act == nw_exp, "R6 write total", nw_act, nw_exp);
    for (int k = 0; k < ne && k < tr_n; k++) begin
      logic [12:0] a, e;
      a = tr_log[k]; e = ex_log[k];
      if (!a[12]) a[7:0] = 8'd0;
      if (e[12])               chk(a == e, "R5 clear write", a, e);
      else if (e[11:8] == 4'd0) chk(a == e, "R3 poll read", a, e);
      else                     chk(a == e, "R4 flags then data", a, e);
    end
    if (dbl) chk(tr_n == ne, "R9 sequence unaffected", tr_n, ne);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !reg_req && drained == '0, "R1 reset state",
        {busy, done, reg_req, drained}, 0);
    for (int pat = 0; pat <= 8; pat++)
      for (int n = 0; n <= MAX + 1; n++)
        run_case(n, pat, (pat + n) % 3, (n >= 2) && (pat % 2 == 1));
    // count still held while idle (R8)
    repeat (5) @(negedge clk);
    chk(drained == CW'(MAX), "R8 count held idle", int'(drained), MAX);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule